// File: doc/BRIEF.md
# Two-Wire Memory Card Line Symbol Decoder

This block listens passively to the three lines of a synchronous two-wire memory-card link: a reset line, a card clock and a bidirectional data line. A much faster system clock samples all three lines. The block converts the line activity into single-cycle strobes that a transaction tracker further up can consume. The strobes cover reset pulses, start and stop markers, individual data bits and assembled bytes. The block never drives the lines, and it does not decode commands.

A reset pulse is labelled in one of two ways. If the card clock makes a full pulse while the reset line is high, the pulse is a reset that leads to an answer-to-reset. With no full clock pulse, the reset pulse is only an interruption. Start and stop markers are data-line edges that occur while the card clock is high. The tracker raises `phase_busy_i` during output and internal-processing phases. While it is raised, those data-line edges are ordinary traffic and do not count as markers. Data bits are taken on card-clock rising edges and reported on the next falling edge. The bits are packed into bytes, least significant bit first.

Top module: `cardline_sym_dec`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every strobe output is low.
- R2: A high pulse on the reset line that contains a full card-clock pulse (rise, then fall) produces exactly one `rst_evt_o` strobe after the reset line falls, and no `intr_evt_o`.
- R3: A high pulse on the reset line without a full card-clock pulse produces exactly one `intr_evt_o` strobe and no `rst_evt_o`. A card-clock rise alone does not make a full pulse.
- R4: With the reset line low, the card clock high and `phase_busy_i` low, a falling data-line edge produces one `start_o` strobe.
- R5: Under the same conditions, a rising data-line edge produces one `stop_o` strobe.
- R6: While `phase_busy_i` is high, data-line edges produce no `start_o` or `stop_o` strobe.
- R7: With the reset line low, a bit takes its value from the data line at the card-clock rising edge. `bit_vld_o` pulses at the following falling edge, with that value on `bit_val_o`. No bit is reported while the reset line is high.
- R8: Every eighth reported bit also pulses `byte_vld_o`, in the same cycle as its `bit_vld_o`. `byte_o` then holds the eight bits with the first one in bit 0 and the last one in bit 7.
- R9: A reset pulse, an interruption, a start marker and a stop marker each discard any partly collected byte.
- R10: A card-clock falling edge with no captured rising edge before it reports no bit and discards the partly collected byte.
- R11: In any one cycle, at most one of `rst_evt_o`, `intr_evt_o`, `start_o`, `stop_o` and `bit_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_rst_i | input | 1 | Card reset line, active high |
| line_clk_i | input | 1 | Card clock line |
| line_io_i | input | 1 | Card data line |
| phase_busy_i | input | 1 | High during output or processing phases; masks start and stop |
| rst_evt_o | output | 1 | Strobe: reset pulse with a full card-clock pulse |
| intr_evt_o | output | 1 | Strobe: reset pulse without a full card-clock pulse |
| start_o | output | 1 | Strobe: start marker |
| stop_o | output | 1 | Strobe: stop marker |
| bit_vld_o | output | 1 | Strobe: a data bit is complete |
| bit_val_o | output | 1 | Value of the bit being reported |
| byte_vld_o | output | 1 | Strobe: eighth bit of a byte |
| byte_o | output | 8 | Assembled byte, first bit in bit 0 |

## Verification
Suppose the bit counter is not cleared by a marker or by an orphan clock fall. The next byte strobe then arrives a few bits early, and its value is shifted. This shows at the ports within the following byte. Suppose instead the reset classifier keeps a stale clock-pulse flag. The wrong strobe kind then appears three system cycles after the next reset-line fall. A start marker that leaks while the busy mask is raised appears three cycles after the data-line edge, and it also swallows the bit in progress. All of these faults are therefore observed within one byte time of the stimulus.

// File: rtl/cardline_pkg.sv
package cardline_pkg;
  // Per-line view after synchronization: level plus single-cycle edges.
  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_ev_t;

  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned IDX_RST   = 0;
  localparam int unsigned IDX_CLK   = 1;
  localparam int unsigned IDX_IO    = 2;
endpackage

// File: rtl/cardline_sync.sv
module cardline_sync
  import cardline_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     din,
  output line_ev_t ev
);
  // STAGES flops for metastability, plus one for the previous sample.
  logic [STAGES:0] shr;

  always_ff @(posedge clk) begin
    if (rst) shr <= '0;
    else     shr <= {shr[STAGES-1:0], din};
  end

  always_comb begin
    ev.lvl  = shr[STAGES-1];
    ev.rise = shr[STAGES-1] & ~shr[STAGES];
    ev.fall = ~shr[STAGES-1] & shr[STAGES];
  end
endmodule

// File: rtl/cardline_rst_class.sv
module cardline_rst_class
  import cardline_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  line_ev_t rl,
  input  line_ev_t cl,
  output logic     rst_evt_o,
  output logic     intr_evt_o
);
  logic seen_rise, seen_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_rise  <= 1'b0;
      seen_pulse <= 1'b0;
      rst_evt_o  <= 1'b0;
      intr_evt_o <= 1'b0;
    end else begin
      rst_evt_o  <= 1'b0;
      intr_evt_o <= 1'b0;
      if (rl.rise) begin
        seen_rise  <= 1'b0;
        seen_pulse <= 1'b0;
      end else if (rl.lvl) begin
        if (cl.rise) seen_rise <= 1'b1;
        if (cl.fall && seen_rise) seen_pulse <= 1'b1;
      end
      if (rl.fall) begin
        rst_evt_o  <= seen_pulse;
        intr_evt_o <= ~seen_pulse;
        seen_rise  <= 1'b0;
        seen_pulse <= 1'b0;
      end
    end
  end

  // R2
  rst_kind_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_evt_o || intr_evt_o) |-> $past(rl.fall));

  // R3
  no_pulse_no_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (rl.fall && !seen_pulse) |=> !rst_evt_o);
endmodule

// File: rtl/cardline_bits.sv
module cardline_bits
  import cardline_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  line_ev_t     rl,
  input  line_ev_t     cl,
  input  line_ev_t     il,
  input  logic         busy,
  output logic         start_o,
  output logic         stop_o,
  output logic         bit_vld_o,
  output logic         bit_val_o,
  output logic         byte_vld_o,
  output logic [W-1:0] byte_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          have_rise, pend;
  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;
  logic          in_rst, mark_ok, is_start, is_stop;

  always_comb begin
    in_rst   = rl.lvl | rl.fall;
    mark_ok  = ~in_rst & cl.lvl & ~busy;
    is_start = mark_ok & il.fall;
    is_stop  = mark_ok & il.rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_rise  <= 1'b0;
      pend       <= 1'b0;
      cnt        <= '0;
      shreg      <= '0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      bit_vld_o  <= 1'b0;
      bit_val_o  <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      bit_vld_o  <= 1'b0;
      byte_vld_o <= 1'b0;
      if (in_rst) begin
        have_rise <= 1'b0;
        cnt       <= '0;
      end else if (is_start || is_stop) begin
        start_o   <= is_start;
        stop_o    <= is_stop;
        have_rise <= 1'b0;
        cnt       <= '0;
      end else if (cl.rise) begin
        pend      <= il.lvl;
        have_rise <= 1'b1;
      end else if (cl.fall) begin
        have_rise <= 1'b0;
        if (have_rise) begin
          bit_vld_o <= 1'b1;
          bit_val_o <= pend;
          shreg     <= {pend, shreg[W-1:1]};
          if (cnt == LAST) begin
            byte_vld_o <= 1'b1;
            byte_o     <= {pend, shreg[W-1:1]};
            cnt        <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  end

  // R7
  no_bit_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    rl.lvl |=> !bit_vld_o);

  // R6
  busy_masks_marks_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(start_o || stop_o));

  // R8
  byte_last_bit_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> (bit_vld_o && (byte_o[W-1] == bit_val_o)));

  // R10
  orphan_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (cl.fall && !have_rise) |=> !bit_vld_o);
endmodule

// File: rtl/cardline_sym_dec.sv
module cardline_sym_dec
  import cardline_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_rst_i,
  input  logic              line_clk_i,
  input  logic              line_io_i,
  input  logic              phase_busy_i,
  output logic              rst_evt_o,
  output logic              intr_evt_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              bit_vld_o,
  output logic              bit_val_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [NUM_LINES-1:0] raw;
  line_ev_t             ev [NUM_LINES];

  assign raw[IDX_RST] = line_rst_i;
  assign raw[IDX_CLK] = line_clk_i;
  assign raw[IDX_IO]  = line_io_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
    cardline_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (raw[g]),
      .ev  (ev[g])
    );
  end

  cardline_rst_class u_cls (
    .clk        (clk),
    .rst        (rst),
    .rl         (ev[IDX_RST]),
    .cl         (ev[IDX_CLK]),
    .rst_evt_o  (rst_evt_o),
    .intr_evt_o (intr_evt_o)
  );

  cardline_bits #(.W(BYTE_W)) u_bits (
    .clk        (clk),
    .rst        (rst),
    .rl         (ev[IDX_RST]),
    .cl         (ev[IDX_CLK]),
    .il         (ev[IDX_IO]),
    .busy       (phase_busy_i),
    .start_o    (start_o),
    .stop_o     (stop_o),
    .bit_vld_o  (bit_vld_o),
    .bit_val_o  (bit_val_o),
    .byte_vld_o (byte_vld_o),
    .byte_o     (byte_o)
  );

  // R11
  one_symbol_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_evt_o, intr_evt_o, start_o, stop_o, bit_vld_o}));

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> !(rst_evt_o || intr_evt_o || start_o || stop_o || bit_vld_o || byte_vld_o));
endmodule

// File: tb/cardline_sym_dec_test.sv
module cardline_sym_dec_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lrst = 1'b0, lclk = 1'b0, lio = 1'b0, busy = 1'b0;
  logic       rst_evt, intr_evt, start, stop, bvld, bval, yvld;
  logic [7:0] ybyte;

  int n_rst = 0, n_intr = 0, n_start = 0, n_stop = 0, n_bits = 0, n_bytes = 0;
  int bad_multi = 0, bad_pair = 0;
  logic [7:0] last_byte = 8'h00;
  logic       last_bit = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [7:0] VEC [0:5] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h5A};

  always #5 clk = ~clk;

  cardline_sym_dec uut (
    .clk(clk), .rst(rst), .line_rst_i(lrst), .line_clk_i(lclk), .line_io_i(lio),
    .phase_busy_i(busy), .rst_evt_o(rst_evt), .intr_evt_o(intr_evt), .start_o(start),
    .stop_o(stop), .bit_vld_o(bvld), .bit_val_o(bval), .byte_vld_o(yvld), .byte_o(ybyte)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if ((int'(rst_evt) + int'(intr_evt) + int'(start) + int'(stop) + int'(bvld)) > 1)
        bad_multi++;
      if (yvld && !bvld) bad_pair++;
      if (rst_evt) n_rst++;
      if (intr_evt) n_intr++;
      if (start) n_start++;
      if (stop) n_stop++;
      if (bvld) begin n_bits++; last_bit = bval; end
      if (yvld) begin n_bytes++; last_byte = ybyte; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    lio = b;  wt(4);
    lclk = 1; wt(4);
    lclk = 0; wt(4);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic do_start();
    lio = 1;  wt(4);
    lclk = 1; wt(4);
    lio = 0;  wt(4);
    lclk = 0; wt(4);
  endtask

  task automatic do_stop();
    lio = 0;  wt(4);
    lclk = 1; wt(4);
    lio = 1;  wt(4);
    lclk = 0; wt(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    finish_run();
  end

  initial begin
    int b0, s0, k0;
    wt(5);
    // R1: outputs quiet during reset
    chk({rst_evt, intr_evt, start, stop, bvld, yvld} == 6'b0, "R1 during reset",
        {rst_evt, intr_evt, start, stop, bvld, yvld}, 0);
    rst = 0;
    @(negedge clk);
    chk({rst_evt, intr_evt, start, stop, bvld, yvld} == 6'b0, "R1 after reset",
        {rst_evt, intr_evt, start, stop, bvld, yvld}, 0);
    wt(4);

    // R4 R5 R8: table walk, one byte per framed transfer
    for (int v = 0; v < 6; v++) begin
      s0 = n_start; k0 = n_bytes;
      do_start();
      chk(n_start == s0 + 1, "R4 start", n_start, s0 + 1);
      send_byte(VEC[v]);
      chk(n_bytes == k0 + 1 && last_byte == VEC[v], "R8 byte", last_byte, VEC[v]);
      s0 = n_stop;
      do_stop();
      chk(n_stop == s0 + 1, "R5 stop", n_stop, s0 + 1);
    end

    // R2: reset pulse with full clock pulse
    s0 = n_rst; k0 = n_intr; b0 = n_bits;
    lrst = 1; wt(4); lclk = 1; wt(4); lclk = 0; wt(4); lrst = 0; wt(6);
    chk(n_rst == s0 + 1 && n_intr == k0, "R2 reset kind", n_rst - s0, 1);
    // R7: no bit while reset line high
    chk(n_bits == b0, "R7 no bit in reset", n_bits - b0, 0);

    // R3: pulse without clock
    s0 = n_rst; k0 = n_intr;
    lrst = 1; wt(6); lrst = 0; wt(6);
    chk(n_intr == k0 + 1 && n_rst == s0, "R3 interrupt", n_intr - k0, 1);

    // R3 and R10: clock rise only in reset, then orphan fall
    s0 = n_rst; k0 = n_intr;
    lrst = 1; wt(4); lclk = 1; wt(4); lrst = 0; wt(6);
    chk(n_intr == k0 + 1 && n_rst == s0, "R3 rise only", n_intr - k0, 1);
    b0 = n_bits;
    lclk = 0; wt(6);
    chk(n_bits == b0, "R10 orphan fall", n_bits - b0, 0);

    // R9: partial bits discarded by start
    send_bit(1); send_bit(1); send_bit(0);
    k0 = n_bytes;
    do_start();
    send_byte(8'h96);
    chk(n_bytes == k0 + 1 && last_byte == 8'h96, "R9 start discards", last_byte, 8'h96);

    // R9: partial bits discarded by reset pulse
    send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    lrst = 1; wt(6); lrst = 0; wt(6);
    k0 = n_bytes;
    send_byte(8'h4B);
    chk(n_bytes == k0 + 1 && last_byte == 8'h4B, "R9 reset discards", last_byte, 8'h4B);

    // R6 and R7: busy masks markers; value taken at clock rise
    busy = 1;
    s0 = n_start; k0 = n_stop; b0 = n_bits;
    lio = 1; wt(4); lclk = 1; wt(4); lio = 0; wt(4); lclk = 0; wt(6);
    chk(n_start == s0, "R6 start masked", n_start - s0, 0);
    chk(n_bits == b0 + 1 && last_bit == 1'b1, "R7 value at rise", last_bit, 1);
    lclk = 1; wt(4); lio = 1; wt(4); lclk = 0; wt(6);
    chk(n_stop == k0, "R6 stop masked", n_stop - k0, 0);
    chk(last_bit == 1'b0, "R7 value low at rise", last_bit, 0);
    busy = 0;

    // R11 and R8 pairing over the whole run
    chk(bad_multi == 0, "R11 one symbol per cycle", bad_multi, 0);
    chk(bad_pair == 0, "R8 byte with bit", bad_pair, 0);

    wt(4);
    finish_run();
  end
endmodule